// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the low-order address bits for a fixed-length wrapping burst. When the surrounding controller accepts a new external address, it pulses a load input with the low address bits. The block captures them as the start beat and clears its beat index. After that, every rising clock edge with the active-low advance input asserted moves to the next beat. The order of the beats is set by a mode input. In linear order the offset counts up and wraps. In interleaved order the offset is the start value XORed with the beat index, which suits cache-line fills. After the last beat the burst returns to its starting offset. The same sequence serves read and write bursts.

The controller keeps the upper address bits, the memory array and all write control. This block only supplies the changing low bits and the current beat number. The mode input should be held steady for the whole of a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high at a rising edge, the next outputs are `addr_lo_o` = 0 and `beat_o` = 0.
- R2: A rising edge with `load_i` = 1 makes `addr_lo_o` equal to the `start_i` value sampled at that edge. It also makes `beat_o` = 0.
- R3: A rising edge with `load_i` = 0 and `adv_n_i` = 0 increments `beat_o` by one, modulo 4.
- R4: A rising edge with `load_i` = 0 and `adv_n_i` = 1 leaves `beat_o` and `addr_lo_o` unchanged.
- R5: When `load_i` = 1 and `adv_n_i` = 0 at the same edge, the load wins. The result is the same as R2, with no advance.
- R6: With `order_sel_i` = 0 (linear), `addr_lo_o` = (start + `beat_o`) mod 4. For starts 0, 1, 2, 3 the sequences are 0-1-2-3, 1-2-3-0, 2-3-0-1 and 3-0-1-2.
- R7: With `order_sel_i` = 1 (interleaved), `addr_lo_o` = start XOR `beat_o`. For starts 0, 1, 2, 3 the sequences are 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0.
- R8: After the fourth beat the next advance returns `addr_lo_o` to the start value and `beat_o` to 0. Longer bursts repeat the same four-beat sequence.
- R9: A load in the middle of a burst restarts it at the new start value with `beat_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Accept a new start offset |
| start_i | input | BEAT_W | Low address bits of the new address |
| adv_n_i | input | 1 | Advance to the next beat when low |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_lo_o | output | BEAT_W | Current low address bits |
| beat_o | output | BEAT_W | Current beat index within the burst |

## Verification
The bench builds the block with the default `BEAT_W` = 2, which gives four-beat bursts. With this width the whole space is small: every start offset in both orders, each driven for eight beats so that every burst wraps at least once. Directed cases then cover reset, holding with advance high, a load and an advance at the same edge, and a restart in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic load;
        logic step;
    } burst_cmd_t;

    function automatic burst_cmd_t decode_cmd(input logic load, input logic adv_n);
        burst_cmd_t c;
        c.load = load;
        c.step = !load && !adv_n;
        return c;
    endfunction

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_seq_pkg::*;
(
    input  logic       load_i,
    input  logic       adv_n_i,
    output burst_cmd_t cmd_o
);
    always_comb begin
        cmd_o = decode_cmd(load_i, adv_n_i);
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_t        cmd_i,
    input  logic [BEAT_W-1:0] start_i,
    output logic [BEAT_W-1:0] start_q_o,
    output logic [BEAT_W-1:0] beat_q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q_o <= '0;
            beat_q_o  <= '0;
        end else if (cmd_i.load) begin
            start_q_o <= start_i;
            beat_q_o  <= '0;
        end else if (cmd_i.step) begin
            beat_q_o  <= beat_q_o + 1'b1;
        end
    end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  order_e            order_i,
    output logic [BEAT_W-1:0] addr_o
);
    logic [BEAT_W-1:0] lin_addr;
    logic [BEAT_W-1:0] ilv_addr;

    assign lin_addr = start_i + beat_i;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
        assign ilv_addr[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORDER_INTERLEAVE: addr_o = ilv_addr;
            default:          addr_o = lin_addr;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic              adv_n_i,
    input  logic              order_sel_i,
    output logic [BEAT_W-1:0] addr_lo_o,
    output logic [BEAT_W-1:0] beat_o
);
    burst_cmd_t        cmd;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    order_e            order;

    assign order = order_e'(order_sel_i);

    burst_cmd_dec u_dec (
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .cmd_o   (cmd)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .start_i   (start_i),
        .start_q_o (start_q),
        .beat_q_o  (beat_q)
    );

    burst_addr_map #(.BEAT_W(BEAT_W)) u_map (
        .start_i (start_q),
        .beat_i  (beat_q),
        .order_i (order),
        .addr_o  (addr_lo_o)
    );

    assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic [BEAT_W-1:0] start_i,
    input logic              adv_n_i,
    input logic              order_sel_i,
    input logic [BEAT_W-1:0] addr_lo_o,
    input logic [BEAT_W-1:0] beat_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (addr_lo_o == '0) && (beat_o == '0));

    assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_lo_o == $past(start_i)) && (beat_o == '0));

    assert_step_beat_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=> $stable(beat_o) && ($changed(order_sel_i) || $stable(addr_lo_o)));

    assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (load_i && !adv_n_i) |=> beat_o == '0);

    assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i && !order_sel_i) |=>
            order_sel_i || (addr_lo_o == BEAT_W'($past(addr_lo_o) + 1'b1)));

    assert_ilv_const_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && order_sel_i) |=>
            !order_sel_i || ((addr_lo_o ^ beat_o) == $past(addr_lo_o ^ beat_o)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .start_i     (start_i),
    .adv_n_i     (adv_n_i),
    .order_sel_i (order_sel_i),
    .addr_lo_o   (addr_lo_o),
    .beat_o      (beat_o)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int BEAT_W = 2;

    // {order, start, beat0, beat1, beat2, beat3}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 2'd0, 8'h1B}, {1'b0, 2'd1, 8'h6C},
        {1'b0, 2'd2, 8'hB1}, {1'b0, 2'd3, 8'hC6},
        {1'b1, 2'd0, 8'h1B}, {1'b1, 2'd1, 8'h4E},
        {1'b1, 2'd2, 8'hB1}, {1'b1, 2'd3, 8'hE4}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_i = 1'b0;
    logic [BEAT_W-1:0] start_i = '0;
    logic              adv_n_i = 1'b1;
    logic              order_sel_i = 1'b0;
    logic [BEAT_W-1:0] addr_lo_o;
    logic [BEAT_W-1:0] beat_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.BEAT_W(BEAT_W)) i_burst_addr_seq (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .start_i     (start_i),
        .adv_n_i     (adv_n_i),
        .order_sel_i (order_sel_i),
        .addr_lo_o   (addr_lo_o),
        .beat_o      (beat_o)
    );

    task automatic check(input string req, input logic [BEAT_W-1:0] act,
                         input logic [BEAT_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic ld, input logic [BEAT_W-1:0] st,
                         input logic advn, input logic ord);
        @(negedge clk);
        load_i = ld; start_i = st; adv_n_i = advn; order_sel_i = ord;
    endtask

    function automatic logic [1:0] pick(input logic [7:0] seq, input int k);
        return seq[7-2*(k%4) -: 2];
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset
        drive(1'b0, 2'd3, 1'b0, 1'b0);
        tick(); tick();
        check("R1 addr", addr_lo_o, 2'd0);
        check("R1 beat", beat_o, 2'd0);
        @(negedge clk); rst = 1'b0;

        // Table walk: R2, R3, R6, R7, R8
        for (int v = 0; v < 8; v++) begin
            drive(1'b1, VEC[v][9:8], 1'b1, VEC[v][10]);
            tick();
            check("R2 addr", addr_lo_o, VEC[v][9:8]);
            check("R2 beat", beat_o, 2'd0);
            drive(1'b0, 2'd0, 1'b0, VEC[v][10]);
            for (int k = 1; k < 8; k++) begin
                tick();
                check("R3 beat", beat_o, 2'(k % 4));
                if (k >= 4)
                    check("R8 wrap", addr_lo_o, pick(VEC[v][7:0], k));
                else if (VEC[v][10])
                    check("R7 interleaved", addr_lo_o, pick(VEC[v][7:0], k));
                else
                    check("R6 linear", addr_lo_o, pick(VEC[v][7:0], k));
            end
        end

        // R4: hold with advance high
        drive(1'b1, 2'd1, 1'b1, 1'b1);
        tick();
        drive(1'b0, 2'd0, 1'b0, 1'b1);
        tick();
        drive(1'b0, 2'd2, 1'b1, 1'b1);
        tick(); tick(); tick();
        check("R4 addr", addr_lo_o, 2'd0);
        check("R4 beat", beat_o, 2'd1);

        // R5: load and advance together
        drive(1'b1, 2'd3, 1'b0, 1'b0);
        tick();
        check("R5 addr", addr_lo_o, 2'd3);
        check("R5 beat", beat_o, 2'd0);

        // R9: restart mid-burst
        drive(1'b0, 2'd0, 1'b0, 1'b0);
        tick(); tick();
        check("R9 pre", addr_lo_o, 2'd1);
        drive(1'b1, 2'd2, 1'b0, 1'b0);
        tick();
        check("R9 addr", addr_lo_o, 2'd2);
        check("R9 beat", beat_o, 2'd0);
        drive(1'b0, 2'd0, 1'b0, 1'b0);
        tick();
        check("R9 next", addr_lo_o, 2'd3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule